// File: doc/BRIEF.md
# Two-Dimensional Modulo Address Stepper

This block runs beside a byte-moving DMA datapath and walks a rectangular transfer as rows of columns. After each byte the datapath reports, the stepper either bumps its column counter, or closes a row, or ends the job. When it closes a row, it tells each channel (source and target) whether to add a row jump to its address. The jump amount comes back already aligned to the integer part of a fixed-point address that carries eight fraction bits.

A job begins with a start pulse. The start pulse captures the column limit, the row limit, the jump value and the two per-channel jump requests. A global enable can veto both jump requests. The job ends with a one-cycle done pulse. The block holds no addresses and makes no memory accesses. It only produces add-enables and the amount to add.

Top module: `mod2d_stepper`

## Requirements
- R1: After reset, busy, done, src_add_en and dst_add_en are 0, and both col_count and row_count are 0.
- R2: A start pulse clears col_count and row_count to 0 and raises busy in the following cycle.
- R3: A col_limit or row_limit of 0 is captured as 256. A job with limits C and R therefore takes (C+1)*(R+1) steps.
- R4: A step while busy, with col_count not equal to the column limit, raises col_count by one and asserts no add-enable.
- R5: A step while busy, with col_count at the column limit and row_count below the row limit, has four effects in the next cycle. It clears col_count, raises row_count by one, and pulses src_add_en and/or dst_add_en for one cycle, for the channels whose jump was requested at start. It also presents add_amount = mod_value shifted left by 8.
- R6: A step while busy, with both counters at their limits, produces a one-cycle done pulse and drops busy. The counters keep their final values until the next start.
- R7: When mod_global_en is 0 at start, neither add-enable asserts during that job, whatever src_mod_req and dst_mod_req are.
- R8: A step while busy is 0 changes no counter and produces no add-enable or done.
- R9: A start in the same cycle as a step takes priority. The counters restart from 0, and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures configuration and begins a job |
| step | input | 1 | One byte was transferred |
| mod_global_en | input | 1 | Global permission for row jumps |
| src_mod_req | input | 1 | Source channel wants row jumps |
| dst_mod_req | input | 1 | Target channel wants row jumps |
| col_limit | input | 8 | Last column index (0 means 256) |
| row_limit | input | 8 | Last row index (0 means 256) |
| mod_value | input | 16 | Row jump in whole address units |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| src_add_en | output | 1 | Add add_amount to the source address |
| dst_add_en | output | 1 | Add add_amount to the target address |
| add_amount | output | 24 | Captured jump value shifted left by 8 |
| col_count | output | 9 | Current column index |
| row_count | output | 9 | Current row index |

## Verification
The assertions assume the configuration inputs matter only in the cycle that start is high. They also assume step is an ordinary pulse with no meaning outside a job, apart from being ignored. The stimulus sets the limits, the jump value and the flags together with start. It issues steps only as contiguous bursts of exactly the expected job length, except in the deliberate idle-step and restart cases. The abandoned partial job is kept short enough that it never reaches a row boundary, so the scoreboard never expects events from it.

// File: rtl/mod2d_stepper.sv
module mod2d_stepper #(
  parameter int LIM_W  = 8,
  parameter int MOD_W  = 16,
  parameter int FRAC_W = 8,
  localparam int CNT_W = LIM_W + 1,
  localparam int AMT_W = MOD_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             mod_global_en,
  input  logic             src_mod_req,
  input  logic             dst_mod_req,
  input  logic [LIM_W-1:0] col_limit,
  input  logic [LIM_W-1:0] row_limit,
  input  logic [MOD_W-1:0] mod_value,
  output logic             busy,
  output logic             done,
  output logic             src_add_en,
  output logic             dst_add_en,
  output logic [AMT_W-1:0] add_amount,
  output logic [CNT_W-1:0] col_count,
  output logic [CNT_W-1:0] row_count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LIM_W;

  logic [CNT_W-1:0] col_lim_q, row_lim_q;
  logic [MOD_W-1:0] mod_q;
  logic             src_mod_q, dst_mod_q;

  wire [CNT_W-1:0] col_lim_d = (col_limit == '0) ? FULL : CNT_W'(col_limit);
  wire [CNT_W-1:0] row_lim_d = (row_limit == '0) ? FULL : CNT_W'(row_limit);
  wire col_end = (col_count == col_lim_q);
  wire row_end = (row_count == row_lim_q);
  wire adv     = busy && step && !start;

  assign add_amount = {mod_q, FRAC_W'(0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      src_add_en <= 1'b0;
      dst_add_en <= 1'b0;
      col_count  <= '0;
      row_count  <= '0;
      col_lim_q  <= '0;
      row_lim_q  <= '0;
      mod_q      <= '0;
      src_mod_q  <= 1'b0;
      dst_mod_q  <= 1'b0;
    end else begin
      done       <= 1'b0;
      src_add_en <= 1'b0;
      dst_add_en <= 1'b0;
      if (start) begin
        col_lim_q <= col_lim_d;
        row_lim_q <= row_lim_d;
        mod_q     <= mod_value;
        src_mod_q <= src_mod_req && mod_global_en;
        dst_mod_q <= dst_mod_req && mod_global_en;
        col_count <= '0;
        row_count <= '0;
        busy      <= 1'b1;
      end else if (adv) begin
        if (col_end && row_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (col_end) begin
          col_count  <= '0;
          row_count  <= row_count + 1'b1;
          src_add_en <= src_mod_q;
          dst_add_en <= dst_mod_q;
        end else begin
          col_count <= col_count + 1'b1;
        end
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R5
  add_at_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_add_en || dst_add_en) |-> (col_count == '0 && row_count != '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(col_count) && $stable(row_count) && !src_add_en && !dst_add_en));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !col_end) |=> (col_count == $past(col_count) + 1'b1 && !src_add_en && !dst_add_en));

  // R7
  veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !mod_global_en) |=> (!src_mod_q && !dst_mod_q));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && col_count == '0 && row_count == '0));

endmodule

// File: tb/mod2d_stepper_bench.sv
`timescale 1ns/1ps
module mod2d_stepper_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, step = 0, mod_global_en = 0, src_mod_req = 0, dst_mod_req = 0;
  logic [7:0] col_limit = 0, row_limit = 0;
  logic [15:0] mod_value = 0;
  logic busy, done, src_add_en, dst_add_en;
  logic [23:0] add_amount;
  logic [8:0] col_count, row_count;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [26:0] expq[$];

  always #2 clk = ~clk;

  mod2d_stepper u_mod2d_stepper (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .mod_global_en(mod_global_en), .src_mod_req(src_mod_req), .dst_mod_req(dst_mod_req),
    .col_limit(col_limit), .row_limit(row_limit), .mod_value(mod_value),
    .busy(busy), .done(done), .src_add_en(src_add_en), .dst_add_en(dst_add_en),
    .add_amount(add_amount), .col_count(col_count), .row_count(row_count));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (done || src_add_en || dst_add_en)) begin
      logic [26:0] obs, exp;
      obs = {done, src_add_en, dst_add_en, (src_add_en || dst_add_en) ? add_amount : 24'h0};
      if (expq.size() == 0) exp = '0;
      else exp = expq.pop_front();
      check(done ? "R6 done event" : "R5 row jump event", 32'(obs), 32'(exp));
    end
  end

  task automatic run_job(input int cl, input int rl, input logic [15:0] mv,
                         input bit ge, input bit sf, input bit df);
    int c = (cl == 0) ? 256 : cl;
    int r = (rl == 0) ? 256 : rl;
    bit es = sf && ge, ed = df && ge;
    for (int i = 0; i < r; i++)
      if (es || ed) expq.push_back({1'b0, es, ed, mv, 8'h00});
    expq.push_back({1'b1, 2'b00, 24'h0});
    @(negedge clk);
    start = 1; col_limit = 8'(cl); row_limit = 8'(rl); mod_value = mv;
    mod_global_en = ge; src_mod_req = sf; dst_mod_req = df;
    @(negedge clk);
    start = 0;
    check("R2 busy after start", 32'(busy), 1);
    check("R2 col cleared", 32'(col_count), 0);
    check("R2 row cleared", 32'(row_count), 0);
    step = 1;
    repeat ((c + 1) * (r + 1)) @(negedge clk);
    step = 0;
    check("R6 busy dropped", 32'(busy), 0);
    check("R6 col held", 32'(col_count), 32'(c));
    check("R6 row held", 32'(row_count), 32'(r));
    @(negedge clk);
    check("R6 col still held", 32'(col_count), 32'(c));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 outputs", 32'({done, src_add_en, dst_add_en}), 0);
    check("R1 counters", 32'({col_count, row_count}), 0);
    rst_n = 1;
    @(negedge clk);

    // R8: step while idle
    step = 1; @(negedge clk); step = 0; @(negedge clk);
    check("R8 idle step col", 32'(col_count), 0);
    check("R8 idle step row", 32'(row_count), 0);

    run_job(3, 2, 16'h1234, 1, 1, 0);
    run_job(1, 4, 16'h00ff, 1, 0, 1);
    run_job(2, 1, 16'hbeef, 1, 1, 1);
    // R7: global veto
    run_job(2, 3, 16'h5555, 0, 1, 1);
    // R3: zero limits mean 256
    run_job(0, 1, 16'h0001, 1, 1, 0);
    run_job(2, 0, 16'h0002, 1, 0, 1);

    // R8: step after done is ignored
    step = 1; @(negedge clk); step = 0; @(negedge clk);
    check("R8 post-done col", 32'(col_count), 2);
    check("R8 post-done row", 32'(row_count), 256);

    // R4 and R9: partial job, then restart together with a step
    @(negedge clk);
    start = 1; col_limit = 8'd9; row_limit = 8'd1; mod_value = 16'h0;
    mod_global_en = 1; src_mod_req = 1; dst_mod_req = 0;
    @(negedge clk); start = 0;
    step = 1; repeat (3) @(negedge clk); step = 0;
    check("R4 col after three steps", 32'(col_count), 3);
    check("R4 row unchanged", 32'(row_count), 0);
    start = 1; step = 1; col_limit = 8'd1; row_limit = 8'd1;
    @(negedge clk); start = 0; step = 0;
    check("R9 start wins col", 32'(col_count), 0);
    check("R9 start wins busy", 32'(busy), 1);
    expq.push_back({1'b0, 1'b1, 1'b0, 16'h0, 8'h00});
    expq.push_back({1'b1, 2'b00, 24'h0});
    step = 1; repeat (4) @(negedge clk); step = 0;
    check("R6 restarted job ended", 32'(busy), 0);

    repeat (3) @(negedge clk);
    check("R5 all expected events seen", 32'(expq.size()), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule